// File: doc/BRIEF.md
# Interrupt priority level resolver

This block decides, cycle by cycle, whether a pending interrupt is accepted. Two request vectors feed it: a software request vector and an external interrupt status vector. Each has its own configurable bit range. The block folds both vectors into a single priority level and a summary bitmap. It compares that level against the current interrupt priority level. When the interrupt is accepted, it emits a one-cycle strobe together with the level and the summary, ready to be latched into the interrupt ID and summary registers.

Evaluation starts from a check request. The request is remembered until an evaluation actually happens. No evaluation starts while the core runs in its privileged mode. If the in-flight instruction buffer still holds work, the block enters a blocked state and waits for the buffer to drain before it accepts. A non-zero asynchronous trap request seen at evaluation is unsupported, so it sets a sticky error flag.

Top module: `irq_level_resolver`

## Requirements
- R1: A software request bit i with SW_LO <= i <= SW_HI gives candidate level i - SW_LO + 1. When several are set, the highest index gives the level.
- R2: An external bit i with EX_LO <= i <= EX_HI gives candidate level i, and the highest set index wins. Whenever any in-range external bit is set, the external level replaces the software level.
- R3: The summary holds every in-range set bit of both vectors at its own bit position. Bits outside both ranges are ignored. When no in-range bit is set, there is no interrupt and no take.
- R4: An evaluation takes the interrupt only when the resolved level is non-zero and strictly greater than cur_ipl. take_o, level_o and summary_o appear one clock after the evaluation cycle. level_o and summary_o change only on a take and otherwise hold their values.
- R5: check_req sets a pending flag, and the flag is cleared in the cycle an evaluation is accepted. Without a pending check, no interrupt is taken. take_o is high for exactly one cycle per accepted check.
- R6: While priv_mode is high, no evaluation is accepted and the pending check is retained. The pending check is evaluated once priv_mode falls.
- R7: If an evaluation is due while buf_empty is low, blocked_o is set one clock later and nothing is taken. Once buf_empty is high, the evaluation is accepted.
- R8: If buf_empty goes high while blocked_o is set and priv_mode is high, blocked_o clears and nothing is taken.
- R9: A non-zero async_req in an accepted evaluation sets async_err_o one clock later, and it stays set until reset.
- R10: After reset, take_o, level_o, summary_o, blocked_o and async_err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_req | input | 1 | Request to check for interrupts |
| sw_req | input | VW | Software interrupt request vector |
| ext_pend | input | VW | External interrupt status vector |
| cur_ipl | input | LW | Current interrupt priority level |
| priv_mode | input | 1 | Core is in privileged mode |
| buf_empty | input | 1 | In-flight instruction buffer is empty |
| async_req | input | 8 | Asynchronous trap request value |
| take_o | output | 1 | One-cycle interrupt accept strobe |
| level_o | output | LW | Level to latch into the interrupt ID register |
| summary_o | output | VW | Bitmap to latch into the interrupt summary register |
| blocked_o | output | 1 | Acceptance deferred until the buffer drains |
| async_err_o | output | 1 | Sticky unsupported asynchronous trap flag |

## Verification
The level logic is driven with these patterns:
- a single software bit at the bottom of its range, which shows the offset-by-one mapping;
- several software bits, which show that the highest index wins;
- software and external bits together, which show the external override;
- bits outside both ranges only, which show that the ranges are masked.

The compare against cur_ipl is tried with the level equal to cur_ipl and with the level one above it, so a non-strict compare is caught. Directed sequences then separate the gating paths. They check idle inputs with no check request, retention of a pending check across privileged mode, deferral while the buffer is full, the drop of a blocked check on entry into privileged mode, and the stickiness of the asynchronous trap error.

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int VW    = 64,
  parameter int SW_LO = 1,
  parameter int SW_HI = 15,
  parameter int EX_LO = 16,
  parameter int EX_HI = 31,
  parameter int LW    = $clog2(VW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          check_req,
  input  logic [VW-1:0] sw_req,
  input  logic [VW-1:0] ext_pend,
  input  logic [LW-1:0] cur_ipl,
  input  logic          priv_mode,
  input  logic          buf_empty,
  input  logic [7:0]    async_req,
  output logic          take_o,
  output logic [LW-1:0] level_o,
  output logic [VW-1:0] summary_o,
  output logic          blocked_o,
  output logic          async_err_o
);

  logic [LW-1:0] sw_lvl, ex_lvl, lvl_c;
  logic [VW-1:0] sum_c;
  logic          ex_any, present, chk_pend, pend_eff, go, accept, hit;

  always_comb begin
    sum_c  = '0;
    sw_lvl = '0;
    ex_lvl = '0;
    ex_any = 1'b0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req[i]) begin
        sw_lvl   = LW'(i - SW_LO + 1);
        sum_c[i] = 1'b1;
      end
    end
    for (int i = EX_LO; i <= EX_HI; i++) begin
      if (ext_pend[i]) begin
        ex_lvl   = LW'(i);
        ex_any   = 1'b1;
        sum_c[i] = 1'b1;
      end
    end
  end

  assign lvl_c    = ex_any ? ex_lvl : sw_lvl;
  assign present  = |sum_c;
  assign pend_eff = chk_pend | check_req;
  assign go       = blocked_o | (pend_eff & present & ~priv_mode);
  assign accept   = go & buf_empty & ~priv_mode;
  assign hit      = accept & (lvl_c != '0) & (lvl_c > cur_ipl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_pend    <= 1'b0;
      blocked_o   <= 1'b0;
      take_o      <= 1'b0;
      level_o     <= '0;
      summary_o   <= '0;
      async_err_o <= 1'b0;
    end else begin
      chk_pend    <= accept ? 1'b0 : pend_eff;
      blocked_o   <= go & ~buf_empty;
      take_o      <= hit;
      async_err_o <= async_err_o | (accept & (|async_req));
      if (hit) begin
        level_o   <= lvl_c;
        summary_o <= sum_c;
      end
    end
  end

  // R4
  take_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (level_o > $past(cur_ipl)));
  // R5
  take_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(chk_pend | check_req | blocked_o));
  // R6
  take_not_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !$past(priv_mode));
  // R7
  take_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(buf_empty) && !blocked_o));
  // R9
  async_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_err_o |=> async_err_o);

endmodule

// File: tb/tb_irq_level_resolver.sv
module tb_irq_level_resolver;
  localparam int VW = 64;
  localparam int LW = 6;

  logic          clk = 0, rst_n = 0, check_req = 0, priv_mode = 0, buf_empty = 1;
  logic [VW-1:0] sw_req = '0, ext_pend = '0;
  logic [LW-1:0] cur_ipl = '0;
  logic [7:0]    async_req = '0;
  logic          take_o, blocked_o, async_err_o;
  logic [LW-1:0] level_o;
  logic [VW-1:0] summary_o;
  int tests = 0, fails = 0;

  irq_level_resolver dut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [63:0] sw; logic [63:0] ext; logic [5:0] ipl;
    logic tk; logic [5:0] lv; logic [63:0] sm;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{64'h2,        64'h0,                  6'd0,  1'b1, 6'd1,  64'h2},
    '{64'h88,       64'h0,                  6'd0,  1'b1, 6'd7,  64'h88},
    '{64'h8000,     64'h0,                  6'd15, 1'b0, 6'd7,  64'h88},
    '{64'h8000,     64'h0,                  6'd14, 1'b1, 6'd15, 64'h8000},
    '{64'h8000,     64'h10000,              6'd0,  1'b1, 6'd16, 64'h18000},
    '{64'h4,        64'h8010_0000,          6'd20, 1'b1, 6'd31, 64'h8010_0004},
    '{64'h7FFE,     64'h20000,              6'd16, 1'b1, 6'd17, 64'h27FFE},
    '{64'h100_0000_0001, 64'h100_0000_0000, 6'd0,  1'b0, 6'd17, 64'h27FFE},
    '{64'h0,        64'h8000_0000,          6'd30, 1'b1, 6'd31, 64'h8000_0000},
    '{64'h0,        64'h10000,              6'd16, 1'b0, 6'd31, 64'h8000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_check();
    check_req = 1;
    cyc();
    check_req = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1;
    cyc();
    // R10 reset state
    chk("R10 take", take_o, 0);
    chk("R10 level", level_o, 0);
    chk("R10 summary", summary_o, 0);
    chk("R10 blocked", blocked_o, 0);
    chk("R10 async", async_err_o, 0);

    // R1 R2 R3 R4 table
    for (int k = 0; k < 10; k++) begin
      sw_req = VEC[k].sw; ext_pend = VEC[k].ext; cur_ipl = VEC[k].ipl;
      pulse_check();
      chk($sformatf("R4 row%0d take", k), take_o, VEC[k].tk);
      chk($sformatf("R1/R2 row%0d level", k), level_o, VEC[k].lv);
      chk($sformatf("R3 row%0d summary", k), summary_o, VEC[k].sm);
    end

    // R5 no check, no take
    sw_req = 64'h20; ext_pend = 0; cur_ipl = 0;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R5 idle take", take_o, 0);
    end
    // R5 single pulse
    pulse_check();
    chk("R5 pulse take", take_o, 1);
    chk("R5 pulse level", level_o, 5);
    chk("R5 pulse summary", summary_o, 64'h20);
    cyc();
    chk("R5 pulse ends", take_o, 0);

    // R6 privileged hold, pending retained
    priv_mode = 1; sw_req = 64'h200;
    pulse_check();
    chk("R6 priv take", take_o, 0);
    cyc();
    chk("R6 priv take2", take_o, 0);
    priv_mode = 0;
    cyc();
    chk("R6 resume take", take_o, 1);
    chk("R6 resume level", level_o, 9);

    // R7 drain deferral
    buf_empty = 0; sw_req = 64'h1000;
    pulse_check();
    chk("R7 blocked", blocked_o, 1);
    chk("R7 no take", take_o, 0);
    cyc(); cyc();
    chk("R7 still blocked", blocked_o, 1);
    chk("R7 still no take", take_o, 0);
    buf_empty = 1;
    cyc();
    chk("R7 drained take", take_o, 1);
    chk("R7 drained level", level_o, 12);
    chk("R7 unblocked", blocked_o, 0);

    // R8 blocked then privileged at drain
    buf_empty = 0; sw_req = 64'h10;
    pulse_check();
    chk("R8 blocked", blocked_o, 1);
    priv_mode = 1; buf_empty = 1;
    cyc();
    chk("R8 blocked drops", blocked_o, 0);
    chk("R8 no take", take_o, 0);
    cyc();
    chk("R8 no take2", take_o, 0);
    priv_mode = 0;
    cyc();
    chk("R8 later take", take_o, 1);
    chk("R8 later level", level_o, 4);

    // R9 async trap error
    async_req = 8'h1; sw_req = 64'h40;
    pulse_check();
    chk("R9 err set", async_err_o, 1);
    chk("R9 take", take_o, 1);
    async_req = 0;
    cyc(); cyc();
    chk("R9 err sticky", async_err_o, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule